// File: doc/BRIEF.md
# Integer to Complex-Binary Converter

This block turns a 16-bit unsigned magnitude and a sign flag into the radix (−1+j) bit string of that integer. In this string, bit i carries the weight (−1+j)^i. The caller pulses a start strobe while the block is idle. The block raises busy for the length of the conversion, then pulses done for one cycle, and from that cycle on the result is valid.

Inside, the magnitude is cut into radix-4 digits by repeated division by four. Each digit is written with a sign so that the digit string reads as a radix −4 number: odd positions are negated for a positive input, and even positions for a negative input. One cell per clock, the signed digits are then pushed into the range 0..3. A negative digit gains four and passes +1 to its upper neighbour. A digit of four drops to zero and passes −1 upward. Passes over all digits repeat until one pass changes nothing. Each final digit becomes a 4-bit group, so a digit of weight (−4)^k fills output bits 4k+3..4k.

Top module: `cbx_int_conv`

## Requirements
- R1: During reset and right after it, busy_o and done_o are 0 and result_o is all zero.
- R2: start_i is taken only while both busy_o and done_o are low. When it is taken, busy_o is 1 in the following cycle. A start_i seen in the done cycle has no effect.
- R3: For a positive input N, result_o is the radix (−1+j) string of N. Digit k of the radix −4 form maps to result_o[4k+3:4k] with 0→0000, 1→0001, 2→1100, 3→1101. For example, 1 gives 0x1, 2 gives 0xC and 3 gives 0xD.
- R4: Digits at odd positions enter the radix −4 string negated and are then normalised with carries. So 4 gives 0x1D0, 5 gives 0x1D1 and 16 gives 0x100.
- R5: When neg_i is 1, result_o is the string of −N, which equals the positive string multiplied by 11101. So −1 gives 0x1D, −2 gives 0x1C and −4 gives 0x10.
- R6: An input of zero, with either sign, gives an all-zero result_o. done_o rises exactly 1+NDIG clock edges after the start edge (11 at default sizing), which is the shortest possible conversion.
- R7: done_o is high for exactly one cycle, with busy_o low. result_o then holds its value until the next accepted start.
- R8: A start_i pulse while busy_o is high is ignored, and the running conversion finishes with the result of the first operand.
- R9: The full magnitude 65535 converts correctly with either sign within the 40 output bits, and no carry leaves the top digit.
- R10: Every 4-bit group of result_o is one of 0x0, 0x1, 0xC or 0xD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a conversion when the block is idle |
| value_i | input | 16 | Unsigned magnitude, sampled with start_i |
| neg_i | input | 1 | Sign of the operand (1 = negative), sampled with start_i |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when result_o becomes valid |
| result_o | output | 40 | Radix (−1+j) bit string, four bits per radix −4 digit |

## Verification
Suppose a digit is negated at the wrong position or a carry goes in the wrong direction. Then the wrong group appears in result_o in the done cycle, and small operands such as 4 or −2 already expose the error. A carry that gets lost shows up either as a group outside the four legal codes or as a mismatch against an independent digit-by-digit division by (−1+j). A control fault that adds or drops a normalisation pass moves the done cycle, and the bench measures this exactly for a zero operand.

// File: rtl/cbx_pkg.sv
// Shared types for the complex-binary converter.
// Assumes digits stay within -4..4, so a 4-bit signed type is enough.
package cbx_pkg;
    typedef logic signed [3:0] digit_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SPLIT, ST_NORM, ST_DONE} conv_state_t;

    // Maps a normalised radix -4 digit to its 4-bit complex-binary group.
    function automatic logic [3:0] digit_to_nibble(input digit_t d);
        case (d)
            4'sd1:   return 4'b0001;
            4'sd2:   return 4'b1100;
            4'sd3:   return 4'b1101;
            default: return 4'b0000;
        endcase
    endfunction
endpackage

// File: rtl/cbx_splitter.sv
// Splits the magnitude into radix-4 digits, one per step, least significant
// first, and gives each digit the sign that makes the string radix -4.
// Assumes load and step are never high together.
module cbx_splitter
    import cbx_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [IN_W-1:0]  value_i,
    input  logic             neg_i,
    output digit_t           digit_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);
    localparam logic [IDX_W-1:0] MAX_DIGS = IDX_W'((IN_W + 1) / 2);

    logic [IN_W-1:0]  quot_q;
    logic             neg_q;
    logic [IDX_W-1:0] idx_q;
    digit_t           base4;

    // Quotient register: divides by four on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_q <= '0;
            neg_q  <= 1'b0;
            idx_q  <= '0;
        end else if (load) begin
            quot_q <= value_i;
            neg_q  <= neg_i;
            idx_q  <= '0;
        end else if (step) begin
            quot_q <= quot_q >> 2;
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Current remainder, signed by position parity and operand sign.
    always_comb begin
        base4   = digit_t'({2'b00, quot_q[1:0]});
        digit_o = (idx_q[0] ^ neg_q) ? -base4 : base4;
        idx_o   = idx_q;
        last_o  = ((quot_q >> 2) == '0);
    end

    AST_SPLIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (idx_q < MAX_DIGS)); // R3
endmodule

// File: rtl/cbx_digit_file.sv
// Holds the signed radix -4 digits. Accepts digit writes from the splitter,
// then fixes one digit per cycle in place, moving a +1 or -1 into its upper
// neighbour. Assumes clr, wr_en and nrm_en are mutually exclusive.
module cbx_digit_file
    import cbx_pkg::*;
#(
    parameter int NDIG  = 10,
    parameter int IDX_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  digit_t              wr_dig,
    input  logic                nrm_en,
    input  logic [IDX_W-1:0]    nrm_idx,
    output digit_t [NDIG-1:0]   dig_o,
    output logic                fix_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NDIG - 1);

    digit_t [NDIG-1:0] dig_q;
    digit_t            cur;
    logic              low, high;

    // Classifies the digit under the normalisation pointer.
    always_comb begin
        cur   = dig_q[nrm_idx];
        low   = (cur < 0);
        high  = (cur > 3);
        fix_o = nrm_en && (low || high);
        dig_o = dig_q;
    end

    // Digit storage: clear, load from splitter, or one carry step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dig_q <= '0;
        end else if (wr_en) begin
            dig_q[wr_idx] <= wr_dig;
        end else if (nrm_en) begin
            if (low) begin
                dig_q[nrm_idx] <= cur + 4'sd4;
                if (nrm_idx != LAST)
                    dig_q[nrm_idx + 1'b1] <= dig_q[nrm_idx + 1'b1] + 4'sd1;
            end else if (high) begin
                dig_q[nrm_idx] <= cur - 4'sd4;
                if (nrm_idx != LAST)
                    dig_q[nrm_idx + 1'b1] <= dig_q[nrm_idx + 1'b1] - 4'sd1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (nrm_en && nrm_idx == LAST) |-> !(low || high)); // R9
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_dig >= -4'sd3 && wr_dig <= 4'sd3)); // R4
endmodule

// File: rtl/cbx_nibble_map.sv
// Expands each normalised digit into its 4-bit group. Digit g drives bits
// 4g+3..4g. Assumes the digits are already in 0..3.
module cbx_nibble_map
    import cbx_pkg::*;
#(
    parameter int NDIG = 10
) (
    input  digit_t [NDIG-1:0]   dig_i,
    output logic [4*NDIG-1:0]   bits_o
);
    for (genvar g = 0; g < NDIG; g++) begin : g_grp
        assign bits_o[4*g +: 4] = digit_to_nibble(dig_i[g]);
    end
endmodule

// File: rtl/cbx_int_conv.sv
// Integer to radix (-1+j) converter. Sequences the split, the normalisation
// passes and the done pulse. Assumes start_i is only meaningful when idle.
module cbx_int_conv
    import cbx_pkg::*;
#(
    parameter int  IN_W  = 16,
    localparam int NDIG  = (IN_W + 1) / 2 + 2,
    localparam int OUT_W = 4 * NDIG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IN_W-1:0]   value_i,
    input  logic              neg_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [OUT_W-1:0]  result_o
);
    localparam int IDX_W = $clog2(NDIG);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NDIG - 1);

    conv_state_t       state_q;
    logic [IDX_W-1:0]  pos_q;
    logic              chg_q;
    logic              load, split_en, nrm_en, fix, last;
    digit_t            digit;
    logic [IDX_W-1:0]  wr_idx;
    digit_t [NDIG-1:0] digs;

    // Decodes the state into datapath enables and status outputs.
    always_comb begin
        load     = (state_q == ST_IDLE) && start_i;
        split_en = (state_q == ST_SPLIT);
        nrm_en   = (state_q == ST_NORM);
        busy_o   = split_en || nrm_en;
        done_o   = (state_q == ST_DONE);
    end

    // Sequencer: split, repeated normalisation passes, one done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            chg_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE:  if (start_i) state_q <= ST_SPLIT;
                ST_SPLIT: if (last) begin
                    state_q <= ST_NORM;
                    pos_q   <= '0;
                    chg_q   <= 1'b0;
                end
                ST_NORM: begin
                    if (pos_q == LAST) begin
                        pos_q <= '0;
                        chg_q <= 1'b0;
                        if (!(chg_q || fix)) state_q <= ST_DONE;
                    end else begin
                        pos_q <= pos_q + 1'b1;
                        chg_q <= chg_q || fix;
                    end
                end
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    cbx_splitter #(.IN_W(IN_W), .IDX_W(IDX_W)) split_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(split_en),
        .value_i(value_i), .neg_i(neg_i),
        .digit_o(digit), .idx_o(wr_idx), .last_o(last)
    );

    cbx_digit_file #(.NDIG(NDIG), .IDX_W(IDX_W)) file_i (
        .clk(clk), .rst_n(rst_n), .clr(load), .wr_en(split_en),
        .wr_idx(wr_idx), .wr_dig(digit), .nrm_en(nrm_en), .nrm_idx(pos_q),
        .dig_o(digs), .fix_o(fix)
    );

    cbx_nibble_map #(.NDIG(NDIG)) map_i (
        .dig_i(digs), .bits_o(result_o)
    );

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o)); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o)); // R7
endmodule

// File: tb/cbx_int_conv_tb_top.sv
`timescale 1ns/1ps
module cbx_int_conv_tb_top;
    localparam int IN_W  = 16;
    localparam int NDIG  = (IN_W + 1) / 2 + 2;
    localparam int OUT_W = 4 * NDIG;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             neg = 1'b0;
    logic [IN_W-1:0]  value = '0;
    logic             busy, done;
    logic [OUT_W-1:0] result;
    int               n_chk = 0;
    int               n_fail = 0;

    always #10 clk = ~clk;

    cbx_int_conv #(.IN_W(IN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .value_i(value),
        .neg_i(neg), .busy_o(busy), .done_o(done), .result_o(result)
    );

    typedef struct packed {
        logic [15:0] v;
        logic        s;
        logic [39:0] exp;
    } vec_t;

    // Hand-derived vectors: R3 positives, R4 odd-digit carries, R5 negatives.
    localparam vec_t VECS [10] = '{
        '{16'd1,  1'b0, 40'h1},
        '{16'd2,  1'b0, 40'hC},
        '{16'd3,  1'b0, 40'hD},
        '{16'd4,  1'b0, 40'h1D0},
        '{16'd5,  1'b0, 40'h1D1},
        '{16'd16, 1'b0, 40'h100},
        '{16'd1,  1'b1, 40'h1D},
        '{16'd2,  1'b1, 40'h1C},
        '{16'd4,  1'b1, 40'h10},
        '{16'd3,  1'b0, 40'hD}
    };

    // Independent model: repeated division of a+bj by (-1+j).
    function automatic logic [OUT_W-1:0] ref_cbns(input int mag, input bit s);
        longint a, b, na;
        logic [OUT_W-1:0] r;
        r = '0;
        a = s ? -mag : mag;
        b = 0;
        for (int i = 0; i < OUT_W; i++) begin
            if (((a + b) % 2) != 0) begin
                r[i] = 1'b1;
                a = a - 1;
            end
            na = (b - a) / 2;
            b  = (-a - b) / 2;
            a  = na;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one conversion; cyc = clock edges from the start edge to done.
    task automatic convert(input logic [IN_W-1:0] v, input bit s, output int cyc);
        @(negedge clk);
        value = v; neg = s; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
    endtask

    function automatic int bad_groups(input logic [OUT_W-1:0] r);
        int n = 0;
        for (int g = 0; g < NDIG; g++)
            if (!(r[4*g +: 4] inside {4'h0, 4'h1, 4'hC, 4'hD})) n++;
        return n;
    endfunction

    initial begin
        #(20 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cyc;
        int dcount;
        int vals [7] = '{65535, 12345, 255, 1000, 4096, 43690, 21845};
        logic [OUT_W-1:0] held;

        repeat (3) @(negedge clk);
        check("R1 busy", 64'(busy), 64'(0));
        check("R1 done", 64'(done), 64'(0));
        check("R1 result", 64'(result), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 result after release", 64'(result), 64'(0));

        foreach (VECS[i]) begin
            convert(VECS[i].v, VECS[i].s, cyc);
            check(VECS[i].s ? "R5 vector" : (VECS[i].v >= 4 ? "R4 vector" : "R3 vector"),
                  64'(result), 64'(VECS[i].exp));
        end

        foreach (vals[i]) begin
            for (int s = 0; s < 2; s++) begin
                convert(IN_W'(vals[i]), s[0], cyc);
                if (vals[i] == 65535)
                    check("R9 full range", 64'(result), 64'(ref_cbns(vals[i], s[0])));
                else
                    check(s ? "R5 model" : "R3 model", 64'(result), 64'(ref_cbns(vals[i], s[0])));
                check("R10 group codes", 64'(bad_groups(result)), 64'(0));
            end
        end

        convert('0, 1'b0, cyc);
        check("R6 zero result", 64'(result), 64'(0));
        check("R6 zero latency", 64'(cyc), 64'(1 + NDIG));
        convert('0, 1'b1, cyc);
        check("R6 negative zero result", 64'(result), 64'(0));
        check("R6 negative zero latency", 64'(cyc), 64'(1 + NDIG));

        // R2 / R7 / R8 directed sequence.
        @(negedge clk);
        value = 16'd4; neg = 1'b0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", 64'(busy), 64'(1));
        repeat (3) @(negedge clk);
        value = 16'd3; neg = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dcount = 0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        check("R7 busy low in done cycle", 64'(busy), 64'(0));
        check("R8 start while busy ignored", 64'(result), 64'(40'h1D0));
        value = 16'd2; neg = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 done single cycle", 64'(done), 64'(0));
        held = result;
        repeat (5) begin
            @(negedge clk);
            if (done) dcount++;
        end
        check("R2 start in done cycle ignored", 64'(busy), 64'(0));
        check("R7 no extra done", 64'(dcount), 64'(0));
        check("R7 result held", 64'(result), 64'(held));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule